// File: doc/BRIEF.md
# Read Calibration Sequencer

This block trains the read capture path of a 16-bit DRAM interface. The data bus is handled as two 8-bit lanes, and each lane gets its own input delay setting. The block trains one lane at a time. Lane 0 is always trained first, and lane 1 is trained only after lane 0 has settled on a value. For the lane being trained, the block asks a command scheduler for training reads. These reads come from the DRAM's multi-purpose register, which always returns the eight-beat burst 0,1,0,1,0,1,0,1. The block then compares the captured burst with that pattern. If the burst is wrong, it moves the lane's delay tap up by one step and waits for the path to settle before it reads again. A tap is kept only when four reads in a row match.

The tap values are plain registers, and each has a load strobe that the physical delay elements follow. When the last lane has a tap, the block raises a sticky done flag. It also sends a single-cycle start pulse to the next training stage. That stage is write calibration when the board has output delay elements, and write alignment when it does not. If a lane runs through every tap without a stable match, the block flags an error and starts again from lane 0 with both taps cleared.

The controller has six states:
- SETTLE counts the settle period, then goes to REQ.
- REQ holds the read request until it is granted, then goes to WAIT.
- WAIT waits for the capture data.
  - A match that completes the required run goes to LANE_OK.
  - Any other match goes back to REQ.
  - A mismatch below the top tap goes to SETTLE with the tap stepped up.
  - A mismatch at the top tap goes to FAIL.
- LANE_OK goes to SETTLE for the next lane, or to DONE after the last lane.
- FAIL clears everything and goes to SETTLE.
- DONE is terminal.

Top module: `rdcal_seq`

## Requirements
- R1: A synchronous active-low reset does the following:
  - sets both tap values to 0 and selects lane 0;
  - clears done, error, tap load strobes and both next-stage pulses;
  - enters the settle period, so the first read request appears 8 cycles after reset is released.
- R2: `rd_req` stays high until a cycle with `rd_gnt` high. The block then waits for exactly one `cap_valid` before it evaluates the read. `rd_lane` names the lane being trained.
- R3: A capture matches when every bit of the selected lane's beats equals the training pattern, and a single flipped bit anywhere makes it a mismatch. The encoding is as follows:
  - Lane L occupies `cap_data[L*64 +: 64]`.
  - Beat b occupies bits `[b*8 +: 8]` of that slice.
  - The expected beat is 8'h00 for even b and 8'hFF for odd b.
  - The other lane's slice is ignored.
- R4: After every tap change, `rd_req` rises exactly 8 cycles after the cycle in which `tap_ld` is seen high. The same settle period also precedes the first read of each lane.
- R5: A tap is accepted only after 4 consecutive matching reads at that tap. When a read mismatches, the block does three things:
  - it clears the match run;
  - it raises the lane's tap by 1;
  - it pulses that lane's `tap_ld` bit for one cycle.
- R6: Lane 0 is trained to completion before any lane 1 read is issued, and lane 0 keeps its accepted tap while lane 1 trains. Each lane therefore ends on the lowest tap that gave 4 consecutive matches.
- R7: A mismatch at tap 31 is handled as follows:
  - `cal_err` goes high;
  - both taps return to 0, with both `tap_ld` bits pulsed in the same cycle;
  - training restarts on lane 0.
- R8: When the last lane's tap is accepted, the block completes as follows:
  - `cal_done` goes high and stays high, and `cal_err` is cleared;
  - in the same cycle, exactly one single-cycle pulse fires: `wrcal_go` when `has_out_delay` is 1, otherwise `wralign_go`.
- R9: `tap_val[L*5 +: 5]` carries lane L's current tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| has_out_delay | input | 1 | Board has output delay elements; selects the next stage |
| rd_req | output | 1 | Training read request to the command scheduler |
| rd_lane | output | 1 | Lane currently being trained |
| rd_gnt | input | 1 | Scheduler accepted the training read |
| cap_valid | input | 1 | Capture data for the granted read is valid |
| cap_data | input | 128 | Captured burst, both lanes, 8 beats of 8 bits each |
| tap_val | output | 10 | Per-lane input delay tap values |
| tap_ld | output | 2 | Per-lane load strobe, high for one cycle when a tap changes |
| cal_done | output | 1 | Read calibration complete (sticky) |
| cal_err | output | 1 | A lane ran out of taps; cleared on completion |
| wrcal_go | output | 1 | Start pulse for write calibration |
| wralign_go | output | 1 | Start pulse for write alignment |

## Verification
Lane 0's window start is swept over all 32 taps, and lane 1's start follows a different arithmetic sequence. This sweep tells whether the accepted tap is the lowest passing one at every position, including the edges at tap 0 and tap 31. Below the window, each failing read flips a single bit whose position changes with the tap and the lane. This separates a full-width comparison from one that misses some beats or bits. The other lane's slice carries the inverted pattern, which exposes a wrong lane select. On some runs, the tap just below the window matches three times and then fails; this tells a run counter that resets apart from one that accumulates. A final run leaves lane 1 with no passing tap. It checks the error restart and the recovery that follows, and the grant delay and `has_out_delay` are varied across runs.

// File: rtl/rdcal_pkg.sv
`timescale 1ns/1ps
package rdcal_pkg;
    typedef enum logic [2:0] {
        S_SETTLE  = 3'd0,
        S_REQ     = 3'd1,
        S_WAIT    = 3'd2,
        S_LANE_OK = 3'd3,
        S_FAIL    = 3'd4,
        S_DONE    = 3'd5
    } rdcal_state_t;
endpackage

// File: rtl/rdcal_pattern_match.sv
`timescale 1ns/1ps
// Compares one lane's captured burst with the alternating training pattern.
module rdcal_pattern_match #(
    parameter int LANE_W = 8,
    parameter int BEATS  = 8
) (
    input  logic [LANE_W*BEATS-1:0] beats,
    output logic                    match
);
    logic [LANE_W*BEATS-1:0] expect_w;

    always_comb begin
        for (int b = 0; b < BEATS; b++) begin
            expect_w[b*LANE_W +: LANE_W] = (b % 2 == 1) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
        end
    end

    assign match = (beats == expect_w);
endmodule

// File: rtl/rdcal_settle_timer.sv
`timescale 1ns/1ps
// Counts settle cycles while run is high; done in the last settle cycle.
module rdcal_settle_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == CW'(CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !done) begin
            cnt_q <= cnt_q + CW'(1);
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/rdcal_tap_bank.sv
`timescale 1ns/1ps
// Per-lane tap registers with one-cycle load strobes.
module rdcal_tap_bank #(
    parameter int LANES      = 2,
    parameter int TAP_W      = 5,
    parameter int LANE_IDX_W = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc,
    input  logic [LANE_IDX_W-1:0]   inc_lane,
    input  logic                    clr,
    output logic [LANES*TAP_W-1:0]  taps,
    output logic [LANES-1:0]        ld,
    output logic                    at_max
);
    logic [LANES-1:0] top_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [TAP_W-1:0] t_q;
        logic             ld_q;
        logic             sel;

        assign sel = (inc_lane == LANE_IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                t_q  <= '0;
                ld_q <= 1'b0;
            end else if (clr) begin
                t_q  <= '0;
                ld_q <= 1'b1;
            end else if (inc && sel) begin
                t_q  <= t_q + TAP_W'(1);
                ld_q <= 1'b1;
            end else begin
                ld_q <= 1'b0;
            end
        end

        assign taps[g*TAP_W +: TAP_W] = t_q;
        assign ld[g]                  = ld_q;
        assign top_hit[g]             = sel && (&t_q);
    end

    assign at_max = |top_hit;
endmodule

// File: rtl/rdcal_seq.sv
`timescale 1ns/1ps
// Per-lane read calibration sequencer (top).
module rdcal_seq
    import rdcal_pkg::*;
#(
    parameter int LANES      = 2,
    parameter int LANE_W     = 8,
    parameter int BEATS      = 8,
    parameter int TAP_W      = 5,
    parameter int HITS_NEED  = 4,
    parameter int SETTLE_CYC = 8,
    localparam int LANE_IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          has_out_delay,
    output logic                          rd_req,
    output logic [LANE_IDX_W-1:0]         rd_lane,
    input  logic                          rd_gnt,
    input  logic                          cap_valid,
    input  logic [LANES*BEATS*LANE_W-1:0] cap_data,
    output logic [LANES*TAP_W-1:0]        tap_val,
    output logic [LANES-1:0]              tap_ld,
    output logic                          cal_done,
    output logic                          cal_err,
    output logic                          wrcal_go,
    output logic                          wralign_go
);
    localparam int SLICE_W = LANE_W * BEATS;
    localparam int HIT_W   = $clog2(HITS_NEED + 1);

    rdcal_state_t          st_q, st_d;
    logic [LANE_IDX_W-1:0] lane_q, lane_d;
    logic [HIT_W-1:0]      hits_q, hits_d;
    logic [LANES-1:0]      match_vec;
    logic                  lane_match;
    logic                  settle_done;
    logic                  tap_inc, tap_clr, tap_at_max, finish;
    logic                  err_q, wrcal_q, wralign_q;

    // Pattern comparison, one per lane
    for (genvar g = 0; g < LANES; g++) begin : g_match
        rdcal_pattern_match #(.LANE_W(LANE_W), .BEATS(BEATS)) u_pm (
            .beats (cap_data[g*SLICE_W +: SLICE_W]),
            .match (match_vec[g])
        );
    end
    assign lane_match = match_vec[lane_q];

    rdcal_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q == S_SETTLE),
        .done  (settle_done)
    );

    rdcal_tap_bank #(.LANES(LANES), .TAP_W(TAP_W), .LANE_IDX_W(LANE_IDX_W)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (tap_inc),
        .inc_lane (lane_q),
        .clr      (tap_clr),
        .taps     (tap_val),
        .ld       (tap_ld),
        .at_max   (tap_at_max)
    );

    // Next-state and control decode
    always_comb begin
        st_d    = st_q;
        lane_d  = lane_q;
        hits_d  = hits_q;
        tap_inc = 1'b0;
        tap_clr = 1'b0;
        finish  = 1'b0;
        unique case (st_q)
            S_SETTLE: begin
                if (settle_done) st_d = S_REQ;
            end
            S_REQ: begin
                if (rd_gnt) st_d = S_WAIT;
            end
            S_WAIT: begin
                if (cap_valid) begin
                    if (lane_match) begin
                        if (hits_q == HIT_W'(HITS_NEED - 1)) begin
                            st_d = S_LANE_OK;
                        end else begin
                            hits_d = hits_q + HIT_W'(1);
                            st_d   = S_REQ;
                        end
                    end else begin
                        hits_d = '0;
                        if (tap_at_max) begin
                            st_d = S_FAIL;
                        end else begin
                            tap_inc = 1'b1;
                            st_d    = S_SETTLE;
                        end
                    end
                end
            end
            S_LANE_OK: begin
                hits_d = '0;
                if (lane_q == LANE_IDX_W'(LANES - 1)) begin
                    finish = 1'b1;
                    st_d   = S_DONE;
                end else begin
                    lane_d = lane_q + LANE_IDX_W'(1);
                    st_d   = S_SETTLE;
                end
            end
            S_FAIL: begin
                hits_d  = '0;
                lane_d  = '0;
                tap_clr = 1'b1;
                st_d    = S_SETTLE;
            end
            S_DONE: begin
                st_d = S_DONE;
            end
            default: begin
                st_d = S_SETTLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_SETTLE;
            lane_q <= '0;
            hits_q <= '0;
        end else begin
            st_q   <= st_d;
            lane_q <= lane_d;
            hits_q <= hits_d;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            wrcal_q   <= 1'b0;
            wralign_q <= 1'b0;
        end else begin
            wrcal_q   <= finish && has_out_delay;
            wralign_q <= finish && !has_out_delay;
            if (st_q == S_FAIL) begin
                err_q <= 1'b1;
            end else if (finish) begin
                err_q <= 1'b0;
            end
        end
    end

    assign rd_req     = (st_q == S_REQ);
    assign rd_lane    = lane_q;
    assign cal_done   = (st_q == S_DONE);
    assign cal_err    = err_q;
    assign wrcal_go   = wrcal_q;
    assign wralign_go = wralign_q;
endmodule

// File: rtl/rdcal_seq_chk.sv
`timescale 1ns/1ps
// Temporal checks on the sequencer's ports.
module rdcal_seq_chk #(
    parameter int LANES      = 2,
    parameter int TAP_W      = 5,
    parameter int SETTLE_CYC = 8,
    parameter int LANE_IDX_W = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_req,
    input logic                   rd_gnt,
    input logic [LANE_IDX_W-1:0]  rd_lane,
    input logic [LANES*TAP_W-1:0] tap_val,
    input logic [LANES-1:0]       tap_ld,
    input logic                   cal_done,
    input logic                   cal_err,
    input logic                   wrcal_go,
    input logic                   wralign_go
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    logic [SW-1:0] since_ld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ld <= '0;
        end else if (|tap_ld) begin
            since_ld <= SW'(1);
        end else if (since_ld != SW'(SETTLE_CYC)) begin
            since_ld <= since_ld + SW'(1);
        end
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt) |=> rd_req);

    assert_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (since_ld >= SW'(SETTLE_CYC)));

    assert_ld_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|tap_ld) |-> !rd_req);

    assert_lane_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lane < $past(rd_lane)) |-> (&tap_ld));

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_err) |-> ((tap_val == '0) && (rd_lane == '0) && (&tap_ld)));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done);

    assert_done_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !cal_err);

    assert_one_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrcal_go && wralign_go));
endmodule

bind rdcal_seq rdcal_seq_chk #(
    .LANES(LANES), .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC), .LANE_IDX_W(LANE_IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_lane(rd_lane),
    .tap_val(tap_val), .tap_ld(tap_ld), .cal_done(cal_done), .cal_err(cal_err),
    .wrcal_go(wrcal_go), .wralign_go(wralign_go)
);

// File: tb/tb_rdcal_seq.sv
`timescale 1ns/1ps
module tb_rdcal_seq;
    localparam logic [63:0] GOOD = {4{16'hFF00}};

    logic         clk = 1'b0;
    logic         rst_n;
    logic         has_out_delay;
    logic         rd_req;
    logic [0:0]   rd_lane;
    logic         rd_gnt;
    logic         cap_valid;
    logic [127:0] cap_data;
    logic [9:0]   tap_val;
    logic [1:0]   tap_ld;
    logic         cal_done, cal_err, wrcal_go, wralign_go;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model of the DRAM capture path
    int win_lo [2];
    bit win_empty [2];
    bit flaky [2];
    int reads [2][32];
    bit lane1_seen, order_bad;
    int gnt_wait;
    int rl;
    logic [4:0] rt;

    always #10 clk = ~clk;

    rdcal_seq dut (
        .clk(clk), .rst_n(rst_n), .has_out_delay(has_out_delay),
        .rd_req(rd_req), .rd_lane(rd_lane), .rd_gnt(rd_gnt),
        .cap_valid(cap_valid), .cap_data(cap_data),
        .tap_val(tap_val), .tap_ld(tap_ld), .cal_done(cal_done), .cal_err(cal_err),
        .wrcal_go(wrcal_go), .wralign_go(wralign_go)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tap_of(input int l);
        return int'(tap_val[l*5 +: 5]);
    endfunction

    function automatic bit passes(input int l, input int t);
        if (win_empty[l]) return 1'b0;
        if (t >= win_lo[l] && t <= win_lo[l] + 3) return 1'b1;
        if (flaky[l] && win_lo[l] > 0 && t == win_lo[l] - 1 && reads[l][t] < 3) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [127:0] build(input int l, input int t);
        logic [63:0] mine;
        logic [127:0] d;
        if (passes(l, t)) mine = GOOD;
        else mine = GOOD ^ (64'd1 << ((t * 7 + l * 29) % 64));  // R3 single bit flip
        d = {~GOOD, ~GOOD};                                      // other lane ignored
        d[l*64 +: 64] = mine;
        return d;
    endfunction

    // responder: grants requests and returns a capture
    initial begin
        rd_gnt = 1'b0; cap_valid = 1'b0; cap_data = '0;
        forever begin
            @(negedge clk);
            if (rd_req === 1'b1 && rst_n === 1'b1) begin
                rl = int'(rd_lane);
                rt = tap_val[rl*5 +: 5];
                for (int k = 0; k < gnt_wait; k++) begin
                    @(negedge clk);
                    chk(rd_req === 1'b1, "R2 request held", int'(rd_req), 1);
                end
                rd_gnt = 1'b1;
                @(negedge clk);
                rd_gnt = 1'b0;
                repeat (2) @(negedge clk);
                cap_data = build(rl, int'(rt));
                reads[rl][rt]++;
                if (rl == 1) lane1_seen = 1'b1;
                else if (lane1_seen) order_bad = 1'b1;
                cap_valid = 1'b1;
                @(negedge clk);
                cap_valid = 1'b0;
            end
        end
    end

    // settle monitor: R4
    int scnt = 0;
    bit armed = 1'b0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (|tap_ld) begin
                scnt = 0; armed = 1'b1;
            end else if (armed) begin
                scnt++;
                if (rd_req === 1'b1) begin
                    chk(scnt == 8, "R4 settle after tap load", scnt, 8);
                    armed = 1'b0;
                end
            end
        end else begin
            armed = 1'b0;
        end
    end

    task automatic clear_model();
        for (int l = 0; l < 2; l++)
            for (int t = 0; t < 32; t++) reads[l][t] = 0;
        lane1_seen = 1'b0; order_bad = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_model();
        rst_n = 1'b1;
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        while (cal_done !== 1'b1 && n < 4000) begin
            @(negedge clk); n++;
        end
        ok = (cal_done === 1'b1);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ok;
        int n;
        rst_n = 1'b0; has_out_delay = 1'b0; gnt_wait = 0;
        win_lo[0] = 0; win_lo[1] = 0; win_empty[0] = 0; win_empty[1] = 0;
        flaky[0] = 0; flaky[1] = 0;
        repeat (3) @(negedge clk);
        clear_model();
        rst_n = 1'b1;
        // R1 reset state
        chk(tap_val == 10'd0, "R1 taps zero", int'(tap_val), 0);
        chk(tap_ld == 2'b00 && !cal_done && !cal_err, "R1 flags clear",
            int'({tap_ld, cal_done, cal_err}), 0);
        chk(!rd_req && !wrcal_go && !wralign_go && rd_lane == 1'b0, "R1 idle outputs",
            int'({rd_req, wrcal_go, wralign_go, rd_lane}), 0);
        n = 0;
        do begin @(negedge clk); n++; end while (rd_req !== 1'b1 && n < 50);
        chk(n == 8, "R1 first request after settle", n, 8);

        // sweep of window positions
        for (int lo = 0; lo < 32; lo++) begin
            int lo1;
            lo1 = (lo * 13 + 5) % 32;
            win_lo[0] = lo; win_lo[1] = lo1;
            flaky[0] = (lo % 3 == 1); flaky[1] = (lo % 4 == 2);
            has_out_delay = lo[0];
            gnt_wait = lo % 3;
            do_reset();
            wait_done(ok);
            chk(ok, "R8 done reached", int'(ok), 1);
            chk(tap_of(0) == lo, "R6/R9 lane 0 lowest passing tap", tap_of(0), lo);
            chk(tap_of(1) == lo1, "R6/R9 lane 1 lowest passing tap", tap_of(1), lo1);
            chk(wrcal_go == has_out_delay && wralign_go == !has_out_delay,
                "R8 next stage pulse", int'({wrcal_go, wralign_go}), int'({has_out_delay, !has_out_delay}));
            chk(!cal_err, "R8 no error", int'(cal_err), 0);
            chk(reads[0][lo] == 4, "R5 four reads at accepted tap", reads[0][lo], 4);
            chk(reads[1][lo1] == 4, "R5 four reads at lane 1 tap", reads[1][lo1], 4);
            if (flaky[0] && lo > 0)
                chk(reads[0][lo-1] == 4, "R5 run reset on mismatch", reads[0][lo-1], 4);
            for (int t = 0; t < lo - 1; t++)
                chk(reads[0][t] == 1, "R3 flipped bit rejected", reads[0][t], 1);
            chk(!order_bad, "R6 lane order", int'(order_bad), 0);
            @(negedge clk);
            chk(!wrcal_go && !wralign_go, "R8 single cycle pulse", int'({wrcal_go, wralign_go}), 0);
            chk(cal_done, "R8 done sticky", int'(cal_done), 1);
        end

        // exhaustion on lane 1, then recovery
        win_lo[0] = 4; flaky[0] = 0; flaky[1] = 0; win_empty[1] = 1'b1;
        has_out_delay = 1'b1; gnt_wait = 1;
        do_reset();
        n = 0;
        while (cal_err !== 1'b1 && n < 6000) begin @(negedge clk); n++; end
        chk(cal_err === 1'b1, "R7 error raised", int'(cal_err), 1);
        chk(tap_val == 10'd0, "R7 taps cleared", int'(tap_val), 0);
        chk(tap_ld == 2'b11, "R7 both loads pulsed", int'(tap_ld), 3);
        chk(rd_lane == 1'b0, "R7 restart lane 0", int'(rd_lane), 0);
        chk(reads[1][31] == 1, "R7 top tap tried", reads[1][31], 1);
        chk(!cal_done, "R7 not done", int'(cal_done), 0);
        win_empty[1] = 1'b0; win_lo[1] = 9;
        wait_done(ok);
        chk(ok, "R8 done after recovery", int'(ok), 1);
        chk(tap_of(0) == 4 && tap_of(1) == 9, "R7 recovered taps", int'(tap_val), 9 * 32 + 4);
        chk(!cal_err && wrcal_go && !wralign_go, "R8 error cleared, write cal start",
            int'({cal_err, wrcal_go, wralign_go}), 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule